// File: doc/BRIEF.md
# Mixed-Width Dual-Port Sample Buffer

This block stores 16-bit audio samples arriving on a word-wide write port and lets a byte-oriented consumer drain them through a separate 8-bit read port. The consumer is typically a packet transmitter. Both ports see the same storage. A word address on the write side selects one sample. A byte address on the read side, one bit wider, selects one half of a sample.

A build-time parameter sets the byte order. In the default setting, the most significant byte of each sample is read first. The block does this by exchanging the two halves of the sample before it is stored. The read-side address decoding is the same in both settings.

A single active-low asynchronous reset clears the read output register and stops writes while it is held. The sample storage is not cleared. Reads are registered and have one cycle of latency.

Top module: `sample_buffer`

## Requirements
- R1: While `rstN` is low, `rdData` is 0x00. It goes to 0x00 as soon as `rstN` falls, with no clock edge needed.
- R2: A sample is stored on a rising clock edge only when `wrEn` is high and `rstN` is high. When `wrEn` is low, or `rstN` is low, the stored contents do not change.
- R3: `rdData` shows the byte chosen by the `rdAddr` value sampled at the previous rising edge. Until the next edge it keeps its old value.
- R4: With `BYTE_ORDER_MSB_FIRST` = 1, byte address 2k returns bits 15:8 of word k, and byte address 2k+1 returns bits 7:0 of word k.
- R5: With `BYTE_ORDER_MSB_FIRST` = 0, byte address 2k returns bits 7:0 of word k, and byte address 2k+1 returns bits 15:8 of word k.
- R6: If a read and a write address the same word on the same edge, the read returns the contents from before the write.
- R7: Stored samples keep their values through an assertion of the reset.
- R8: The byte address is one bit wider than the word address. All 2^(WORD_AW+1) byte addresses, up to the last word, return the bytes defined in R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write enable for the sample port |
| wrAddr | input | WORD_AW | Word address for the write |
| wrData | input | SAMPLE_W | Sample to store |
| rdAddr | input | WORD_AW+1 | Byte address for the read |
| rdData | output | SAMPLE_W/2 | Registered byte read from storage |

## Verification
The buffer is first filled with a ramp in which every sample has different high and low halves. Reading all 512 bytes in address order then shows whether the byte order and the decoding of the address bits are correct for both parameter settings at once. A short table of sample patterns follows: all zeros, all ones, alternating bits, a single set bit at each end, and one half full with the other half empty. These patterns expose a swapped or shifted lane that the ramp might hide. Directed sequences cover the remaining cases: a write and a read on the same word in the same cycle, a write attempted with the enable low, a write attempted during reset, and the contents after a reset pulse.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef struct packed {
    logic wrStrobe;    // commit the placed sample this edge
    logic rdHighHalf;  // take the upper storage lane on the read
  } sbufStrobes_t;

endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
(
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         rdLaneBit,
  output logic         rst,
  output sbufStrobes_t strobes
);

  // internal reset polarity is active high
  assign rst = ~rstN;

  // no commit while the block is held in reset
  assign strobes.wrStrobe   = wrEn & rstN;
  // odd byte addresses map to the upper storage lane in every mode
  assign strobes.rdHighHalf = rdLaneBit;

endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int SAMPLE_W             = 16,
  parameter int WORD_AW              = 8,
  parameter int BYTE_ORDER_MSB_FIRST = 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  sbufStrobes_t           strobes,
  input  logic [WORD_AW-1:0]     wrAddr,
  input  logic [SAMPLE_W-1:0]    wrData,
  input  logic [WORD_AW-1:0]     rdWord,
  output logic [SAMPLE_W/2-1:0]  rdData
);

  localparam int BYTE_W = SAMPLE_W / 2;
  localparam int DEPTH  = 1 << WORD_AW;

  logic [SAMPLE_W-1:0] store [DEPTH];
  logic [SAMPLE_W-1:0] placed;

  generate
    if (BYTE_ORDER_MSB_FIRST != 0) begin : g_swapLanes
      // upper half of the sample lands in the lane read at even addresses
      assign placed = {wrData[BYTE_W-1:0], wrData[SAMPLE_W-1:BYTE_W]};
    end else begin : g_keepLanes
      assign placed = wrData;
    end
  endgenerate

  // storage has no reset
  always_ff @(posedge clk) begin
    if (strobes.wrStrobe) store[wrAddr] <= placed;
  end

  // read samples storage before this edge's write lands (old data on collision)
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                     rdData <= '0;
    else if (strobes.rdHighHalf) rdData <= store[rdWord][SAMPLE_W-1:BYTE_W];
    else                         rdData <= store[rdWord][BYTE_W-1:0];
  end

endmodule

// File: rtl/sample_buffer.sv
module sample_buffer
  import sbuf_pkg::*;
#(
  parameter int SAMPLE_W             = 16,
  parameter int WORD_AW              = 8,
  parameter int BYTE_ORDER_MSB_FIRST = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [WORD_AW-1:0]    wrAddr,
  input  logic [SAMPLE_W-1:0]   wrData,
  input  logic [WORD_AW:0]      rdAddr,
  output logic [SAMPLE_W/2-1:0] rdData
);

  logic         rst;
  sbufStrobes_t strobes;

  sbuf_ctrl u_ctrl (
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdLaneBit (rdAddr[0]),
    .rst       (rst),
    .strobes   (strobes)
  );

  sbuf_datapath #(
    .SAMPLE_W             (SAMPLE_W),
    .WORD_AW              (WORD_AW),
    .BYTE_ORDER_MSB_FIRST (BYTE_ORDER_MSB_FIRST)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdWord  (rdAddr[WORD_AW:1]),
    .rdData  (rdData)
  );

endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
  parameter int SAMPLE_W             = 16,
  parameter int WORD_AW              = 8,
  parameter int BYTE_ORDER_MSB_FIRST = 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [WORD_AW-1:0]    wrAddr,
  input logic [SAMPLE_W-1:0]   wrData,
  input logic [WORD_AW:0]      rdAddr,
  input logic [SAMPLE_W/2-1:0] rdData
);

  localparam int  BYTE_W  = SAMPLE_W / 2;
  localparam bit  HI_EVEN = (BYTE_ORDER_MSB_FIRST != 0);

  // edges seen out of reset, saturating; nonzero means $past is meaningful
  logic [1:0] sinceRst;
  logic       armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 3) sinceRst <= sinceRst + 2'd1;
  end
  assign armed = (sinceRst != 2'd0);

  // R1: output is cleared whenever reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |-> (rdData == '0));

  // R3: same address, no intervening write -> output holds
  a_r3_hold_on_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    (armed && rdAddr == $past(rdAddr) && !$past(wrEn)) |=> $stable(rdData));

  // R4 / R5: byte read right after a write shows the correct half of that sample
  a_r4_byte_order: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(wrEn) && rdAddr[WORD_AW:1] == $past(wrAddr))
    |=> (rdData == ((($past(rdAddr[0]) == 1'b0) == HI_EVEN)
                    ? $past(wrData[SAMPLE_W-1:BYTE_W], 2)
                    : $past(wrData[BYTE_W-1:0], 2))));

  // R6: colliding write does not reach the read of the same edge
  a_r6_old_on_collision: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wrEn && wrAddr == rdAddr[WORD_AW:1] &&
     rdAddr == $past(rdAddr) && !$past(wrEn)) |=> $stable(rdData));

endmodule

bind sample_buffer sbuf_checker #(
  .SAMPLE_W             (SAMPLE_W),
  .WORD_AW              (WORD_AW),
  .BYTE_ORDER_MSB_FIRST (BYTE_ORDER_MSB_FIRST)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .rdAddr (rdAddr),
  .rdData (rdData)
);

// File: tb/tb_sample_buffer.sv
`timescale 1ns/1ps
module tb_sample_buffer;

  localparam int WATCHDOG_CYC = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [8:0]  rdAddr = '0;
  logic [7:0]  rdMsb, rdLsb;

  logic [15:0] model [256];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sample_buffer #(.BYTE_ORDER_MSB_FIRST(1)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdMsb));

  sample_buffer #(.BYTE_ORDER_MSB_FIRST(0)) dutNat (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdLsb));

  // {word address, sample}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 16'h0000}, {8'hFF, 16'hFFFF}, {8'h40, 16'hA55A},
    {8'h41, 16'h00FF}, {8'h80, 16'h8001}, {8'h7F, 16'hFF00}
  };

  function automatic logic [7:0] expByte(bit msbFirst, logic [15:0] w, bit lsb);
    return ((lsb == 1'b0) == msbFirst) ? w[15:8] : w[7:0];
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chkBoth(string tag, logic [15:0] w, bit lsb);
    chk({tag, " msb-first"}, rdMsb, expByte(1'b1, w, lsb));
    chk({tag, " lsb-first"}, rdLsb, expByte(1'b0, w, lsb));
  endtask

  task automatic writeWord(logic [7:0] a, logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    model[a] = d;
  endtask

  task automatic readCheck(string tag, logic [8:0] a);
    @(negedge clk); rdAddr = a;
    @(negedge clk); chkBoth(tag, model[a[8:1]], a[0]);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] oldW;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 reset msb-first", rdMsb, 8'h00);
    chk("R1 reset lsb-first", rdLsb, 8'h00);
    rstN = 1'b1;

    // ramp fill, halves always differ
    for (int k = 0; k < 256; k++) writeWord(k[7:0], {k[7:0], ~k[7:0]});

    // R2 R4 R5 R8: drain every byte in order
    for (int a = 0; a < 512; a++) readCheck("R4/R5/R8 ramp drain", a[8:0]);

    // R4 R5: pattern table
    for (int i = 0; i < 6; i++) begin
      writeWord(VEC[i][23:16], VEC[i][15:0]);
      readCheck("R4 table even", {VEC[i][23:16], 1'b0});
      readCheck("R5 table odd", {VEC[i][23:16], 1'b1});
    end

    // R3: one cycle latency, hold before edge
    readCheck("R3 setup", 9'd6);
    @(negedge clk); rdAddr = 9'd7;
    #1 chkBoth("R3 before edge", model[3], 1'b0);
    @(negedge clk); chkBoth("R3 after edge", model[3], 1'b1);

    // R2: enable low does not store
    @(negedge clk); wrEn = 1'b0; wrAddr = 8'd3; wrData = 16'hDEAD;
    @(negedge clk);
    readCheck("R2 wrEn low ignored", 9'd6);
    readCheck("R2 wrEn low ignored", 9'd7);

    // R6: collision returns old data, new data next cycle
    readCheck("R6 setup", 9'd10);
    oldW = model[5];
    @(negedge clk); wrEn = 1'b1; wrAddr = 8'd5; wrData = 16'h5A3C;
    @(negedge clk); wrEn = 1'b0; model[5] = 16'h5A3C;
    chkBoth("R6 collision old", oldW, 1'b0);
    @(negedge clk); chkBoth("R2 write landed", model[5], 1'b0);

    // R1 async, R2 no write in reset, R7 retention
    @(negedge clk); rstN = 1'b0;
    #1 chk("R1 async msb-first", rdMsb, 8'h00);
    chk("R1 async lsb-first", rdLsb, 8'h00);
    @(negedge clk); wrEn = 1'b1; wrAddr = 8'd9; wrData = 16'hBEEF;
    @(negedge clk); wrEn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    readCheck("R2 reset blocks write", 9'd18);
    readCheck("R7 retained", 9'd11);
    readCheck("R7 retained", 9'd510);
    readCheck("R8 last byte", 9'd511);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule